// File: doc/BRIEF.md
# Four-Phase Handshake Transfer Link

This block carries data words from a producing stage to a consuming stage over a return-to-zero request/acknowledge pair. Both sides run on the same clock. Each word takes a full four-phase cycle. The sender raises request with the word on the bus. The receiver raises acknowledge once it has taken the word. The sender then drops request, and the receiver drops acknowledge. A new word may start only after acknowledge is seen low again.

The consuming side signals when it can take the offered word through a consume-ready input. That input may come any number of cycles after request rises, so slow words take longer and fast words finish early. No cycle budget is fixed per word. The producer sees a ready output that rises only once the previous handshake has fully returned to idle.

Top module: `hs_link`

## Requirements
- R1: After a synchronous active-high reset, request, acknowledge and output valid are low and the producer ready output is high.
- R2: Producer ready is high only while the sender is idle and acknowledge is low. A word is taken at a clock edge where producer valid and ready are both high, and request is high in the following cycle.
- R3: Request never rises while acknowledge is high.
- R4: Once raised, request stays high and the data bus stays unchanged until the sender has sampled acknowledge high.
- R5: Acknowledge rises only at an edge where request and consume-ready are both high. Output valid is high for exactly that one following cycle, and the output data then equals the word on the bus.
- R6: Acknowledge stays high while request is high. It falls at the first edge after request is sampled low.
- R7: Request falls at the edge after acknowledge is sampled high. The sender returns to idle only after sampling acknowledge low.
- R8: With consume delays varying from 0 to 7 cycles, every sent word arrives exactly once and in sending order.
- R9: With consume-ready held high, output valid is high in the second cycle after the word is taken, and producer ready is high again in the fifth cycle after it is taken.
- R10: A reset during an unfinished transfer discards that word. It never appears at the output, and the next word sent afterward arrives correctly.
- R11: Producer valid and data are ignored while producer ready is low. A word offered then never appears at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Producer offers a word |
| src_data | input | WIDTH | Producer word |
| src_ready | output | 1 | Sender idle and link returned to zero |
| cons_ready | input | 1 | Consumer can take the offered word |
| link_req | output | 1 | Request line, sender to receiver |
| link_ack | output | 1 | Acknowledge line, receiver to sender |
| link_bus | output | WIDTH | Data bus held by the sender |
| dst_valid | output | 1 | One-cycle pulse: word delivered |
| dst_data | output | WIDTH | Delivered word |

## Verification
The assertions check the line discipline on every cycle. They cover request rising only with acknowledge low, request and bus holding until acknowledge is seen, acknowledge rising only on an offered and consumable word, acknowledge holding until request falls, and the ready output matching the idle state. Only the bench scenarios can show end-to-end properties: words arrive in order with none lost or duplicated across a sweep of consume delays, the exact cycle count of a zero-delay round trip, the discarding of a word cut off by reset, and the ignoring of words offered while the link is busy.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;

  typedef enum logic [1:0] {
    SND_IDLE   = 2'd0,
    SND_REQ_HI = 2'd1,
    SND_REQ_LO = 2'd2
  } snd_state_t;

  typedef enum logic [1:0] {
    RCV_IDLE    = 2'd0,
    RCV_CONSUME = 2'd1,
    RCV_ACK_HI  = 2'd2
  } rcv_state_t;

  // sender step: idle -> request high -> request low (wait ack low) -> idle
  function automatic snd_state_t snd_next(snd_state_t s, logic take, logic ack);
    snd_state_t n;
    n = s;
    case (s)
      SND_IDLE:   n = take ? SND_REQ_HI : SND_IDLE;
      SND_REQ_HI: n = ack  ? SND_REQ_LO : SND_REQ_HI;
      SND_REQ_LO: n = ack  ? SND_REQ_LO : SND_IDLE;
      default:    n = SND_IDLE;
    endcase
    return n;
  endfunction

  // receiver step: idle -> (consume wait) -> ack high -> idle
  function automatic rcv_state_t rcv_next(rcv_state_t s, logic req, logic cons);
    rcv_state_t n;
    n = s;
    case (s)
      RCV_IDLE:    n = !req ? RCV_IDLE : (cons ? RCV_ACK_HI : RCV_CONSUME);
      RCV_CONSUME: n = cons ? RCV_ACK_HI : RCV_CONSUME;
      RCV_ACK_HI:  n = req  ? RCV_ACK_HI : RCV_IDLE;
      default:     n = RCV_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/hs_sender.sv
module hs_sender
  import hs_link_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_valid,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_ready,
  input  logic             ack,
  output logic             req,
  output logic [WIDTH-1:0] bus
);

  snd_state_t state;

  // named internal events
  logic take_word;
  logic saw_ack_hi;
  logic saw_ack_lo;

  assign src_ready  = (state == SND_IDLE) && !ack;
  assign take_word  = src_valid && src_ready;
  assign saw_ack_hi = (state == SND_REQ_HI) && ack;
  assign saw_ack_lo = (state == SND_REQ_LO) && !ack;
  assign req        = (state == SND_REQ_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SND_IDLE;
      bus   <= '0;
    end else begin
      state <= snd_next(state, take_word, ack);
      if (take_word) bus <= src_data;
    end
  end

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    src_ready |-> (!req && !ack));

  // R2
  take_raises_req_chk: assert property (@(posedge clk) disable iff (rst)
    take_word |=> req);

  // R3
  no_req_rise_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!req && ack) |=> !req);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);

  // R4
  bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> $stable(bus));

  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    saw_ack_hi |=> !req);

  // R7
  idle_after_ack_lo_chk: assert property (@(posedge clk) disable iff (rst)
    saw_ack_lo |=> (state == SND_IDLE));

endmodule

// File: rtl/hs_receiver.sv
module hs_receiver
  import hs_link_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [WIDTH-1:0] bus,
  input  logic             cons_ready,
  output logic             ack,
  output logic             dst_valid,
  output logic [WIDTH-1:0] dst_data
);

  rcv_state_t state;

  // named internal events
  logic offer_seen;
  logic consume_now;
  logic release_seen;

  assign offer_seen   = req && ((state == RCV_IDLE) || (state == RCV_CONSUME));
  assign consume_now  = offer_seen && cons_ready;
  assign release_seen = (state == RCV_ACK_HI) && !req;
  assign ack          = (state == RCV_ACK_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RCV_IDLE;
      dst_valid <= 1'b0;
      dst_data  <= '0;
    end else begin
      state     <= rcv_next(state, req, cons_ready);
      dst_valid <= consume_now;
      if (consume_now) dst_data <= bus;
    end
  end

  // R5
  ack_needs_offer_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack && !(req && cons_ready)) |=> !ack);

  // R5
  valid_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    dst_valid |-> ack);

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    dst_valid |=> !dst_valid);

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && req) |=> ack);

  // R6
  ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    release_seen |=> !ack);

endmodule

// File: rtl/hs_link.sv
module hs_link
  import hs_link_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_valid,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_ready,
  input  logic             cons_ready,
  output logic             link_req,
  output logic             link_ack,
  output logic [WIDTH-1:0] link_bus,
  output logic             dst_valid,
  output logic [WIDTH-1:0] dst_data
);

  hs_sender #(.WIDTH(WIDTH)) snd_i (
    .clk       (clk),
    .rst       (rst),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_ready (src_ready),
    .ack       (link_ack),
    .req       (link_req),
    .bus       (link_bus)
  );

  hs_receiver #(.WIDTH(WIDTH)) rcv_i (
    .clk        (clk),
    .rst        (rst),
    .req        (link_req),
    .bus        (link_bus),
    .cons_ready (cons_ready),
    .ack        (link_ack),
    .dst_valid  (dst_valid),
    .dst_data   (dst_data)
  );

  // R3
  link_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(link_req)) |-> !link_ack);

  // R8
  delivered_matches_bus_chk: assert property (@(posedge clk) disable iff (rst)
    dst_valid |-> (dst_data == link_bus));

endmodule

// File: tb/hs_link_tb.sv
module hs_link_tb_top;

  localparam int W = 16;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         src_valid = 1'b0;
  logic [W-1:0] src_data = '0;
  logic         src_ready;
  logic         cons_ready = 1'b0;
  logic         link_req, link_ack;
  logic [W-1:0] link_bus;
  logic         dst_valid;
  logic [W-1:0] dst_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] exp_mem [0:255];
  int tx_idx = 0;
  int rx_idx = 0;
  int cons_mode = 0;   // 0 hold low, 1 tied high, 2 delayed per word
  int cons_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_link #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .cons_ready(cons_ready), .link_req(link_req),
    .link_ack(link_ack), .link_bus(link_bus), .dst_valid(dst_valid),
    .dst_data(dst_data)
  );

  function automatic logic [W-1:0] word_of(int i);
    return W'((i * 16'h2f1b) ^ 16'h5a00) + W'(i);
  endfunction

  function automatic int delay_of(int i);
    return (i * 5 + 3) % 8;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // consumer model
  initial begin
    forever begin
      @(negedge clk);
      if (cons_mode == 1) cons_ready = 1'b1;
      else if (cons_mode == 2 && link_req && !link_ack && !rst) begin
        repeat (delay_of(cons_cnt)) @(negedge clk);
        cons_cnt++;
        cons_ready = 1'b1;
        @(negedge clk);
        cons_ready = 1'b0;
      end else cons_ready = 1'b0;
    end
  end

  // output monitor: R5, R8, R10, R11
  always @(negedge clk) begin
    if (!rst && dst_valid) begin
      if (rx_idx >= tx_idx)
        chk(1'b0, "R8 extra word", int'(dst_data), -1);
      else
        chk(dst_data == exp_mem[rx_idx], "R8 order/data", int'(dst_data), int'(exp_mem[rx_idx]));
      rx_idx++;
    end
  end

  // producer; while busy offers junk (R11) if asked
  task automatic send_word(input logic [W-1:0] w, input bit junk);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      if (src_ready) begin
        src_valid = 1'b1;
        src_data  = w;
        exp_mem[tx_idx] = w;
        tx_idx++;
        @(negedge clk);
        src_valid = 1'b0;
        done = 1;
      end else begin
        src_valid = junk;
        src_data  = ~w;
      end
    end
  endtask

  task automatic drain;
    int t = 0;
    while (rx_idx != tx_idx && t < 200) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(link_req == 0, "R1 req", link_req, 0);
    chk(link_ack == 0, "R1 ack", link_ack, 0);
    chk(dst_valid == 0, "R1 valid", dst_valid, 0);
    chk(src_ready == 1, "R1 ready", src_ready, 1);

    // R9 / R2 zero-delay round trip timing
    cons_mode = 1;
    @(negedge clk);
    src_valid = 1'b1;
    src_data  = 16'hc3a5;
    exp_mem[tx_idx] = 16'hc3a5;
    tx_idx++;
    @(negedge clk);          // cycle 1 after take
    src_valid = 1'b0;
    chk(link_req == 1, "R2 req after take", link_req, 1);
    chk(src_ready == 0, "R2 ready low busy", src_ready, 0);
    chk(dst_valid == 0, "R9 valid not yet", dst_valid, 0);
    @(negedge clk);          // cycle 2
    chk(dst_valid == 1, "R9 valid cycle 2", dst_valid, 1);
    chk(dst_data == 16'hc3a5, "R5 data", int'(dst_data), 16'hc3a5);
    chk(link_ack == 1, "R5 ack up", link_ack, 1);
    @(negedge clk);          // cycle 3
    chk(link_req == 0 && link_ack == 1, "R7 req drops", {link_req, link_ack}, 1);
    chk(dst_valid == 0, "R5 valid one cycle", dst_valid, 0);
    @(negedge clk);          // cycle 4
    chk(link_ack == 0, "R6 ack falls", link_ack, 0);
    chk(src_ready == 0, "R7 not idle yet", src_ready, 0);
    @(negedge clk);          // cycle 5
    chk(src_ready == 1, "R9 ready cycle 5", src_ready, 1);

    // back-to-back with tied consumer and junk offers (R11)
    for (int i = 0; i < 8; i++) send_word(word_of(100 + i), 1'b1);
    drain();

    // R8 sweep of consume delays 0..7 (i*5+3 mod 8 covers all)
    cons_mode = 2;
    for (int i = 0; i < NWORDS; i++) send_word(word_of(i), i[0]);
    drain();
    chk(rx_idx == tx_idx, "R8 count", rx_idx, tx_idx);

    // R10 reset mid transfer
    cons_mode = 0;
    @(negedge clk);
    send_word(16'hdead, 1'b0);
    tx_idx--;                // discarded: not expected
    repeat (3) @(negedge clk);
    chk(link_req == 1 && link_ack == 0, "R10 in flight", {link_req, link_ack}, 2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(link_req == 0 && link_ack == 0, "R10 lines low", {link_req, link_ack}, 0);
    chk(src_ready == 1, "R10 ready", src_ready, 1);
    repeat (10) @(negedge clk);
    chk(rx_idx == tx_idx, "R10 no delivery", rx_idx, tx_idx);
    cons_mode = 2;
    send_word(16'h1357, 1'b0);
    drain();
    chk(rx_idx == tx_idx, "R10 next word", rx_idx, tx_idx);

    summary();
  end

endmodule